// File: doc/BRIEF.md
# Sub-addressed I2C Control and Status Target for a Clock Recovery Receiver

This block is the register port of a clock and data recovery receiver. A board controller reaches it over a two-wire I2C bus. The block gives the controller access to a small byte-wide register file that has two kinds of entry. The read-only entries present the measured data-rate words and the lock and measurement flags, which arrive on input ports. The write-only entries set up the reference band and the divide ratio. They also start a rate measurement, choose between reference lock and data lock, set the lock-indicator mode, set the squelch policy and set the output swing boost.

The target answers to a 7-bit address. Its top bit is 1, bit 5 follows a board pin, and the other bits are 0. A write transfer sends a sub-address and then any number of data bytes. A read uses the combined format: a write of the sub-address, a repeated START, and then data bytes sent by the target. In both directions the sub-address advances by one after every data byte. Three control bits act as one-shot clears or resets. They fire only when a write turns a 1 that is already stored into a 0. The squelch input gates the recovered data and clock enables according to the policy bit.

SCL and SDA are synchronised into the system clock domain. All bus events are taken from the synchronised edges. The block does not stretch the clock.

Top module: `cdr_i2c_ctrl`

## Requirements
- R1: The target acknowledges only the address byte whose upper seven bits equal {1, addr_pin_i, 00000}. Bit 0 of that byte is 0 for a write and 1 for a read. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R2: In a write transfer the first byte after the address is the sub-address. Every following data byte is acknowledged, is written at the current sub-address, and then advances the sub-address by one.
- R3: In a combined read, after a repeated START and an address byte with bit 0 = 1, the target sends the byte at the current sub-address MSB first and advances the sub-address by one. It sends the next byte only if the controller acknowledged the previous one. A not-acknowledge ends the transfer.
- R4: The read-only map is as follows. Sub-addresses 0x00, 0x01 and 0x02 return rate_fine_i bits [7:0], [15:8] and [23:16]. Sub-address 0x03 returns rate_coarse_i[8:1]. Sub-address 0x04 returns lol_sticky_i at bit 4, lol_now_i at bit 3, meas_done_i at bit 2 and rate_coarse_i[0] at bit 0, with bits 7..5 and 1 read as 0.
- R5: The control byte at sub-address 0x08 drives ref_band_o from bits 7:6, ratio_code_o from bits 5:2, meas_start_o from bit 1 and ref_lock_o from bit 0.
- R6: At sub-address 0x09, bit 7 drives lol_static_o. Bits 6, 5 and 3 drive clr_lol_o, sys_rst_o and clr_meas_o. Each of these outputs gives a single-cycle pulse only when a write stores 0 into that bit while the bit held 1. Writing 1, or writing 0 over a 0, gives no pulse.
- R7: At sub-address 0x11, bit 0 drives boost_o and bit 1 selects the squelch policy. With the policy bit at 0, squelch_i high drops both data_out_en_o and clk_out_en_o. With the policy bit at 1, squelch_i high drops only data_out_en_o and clk_out_en_o stays high. With squelch_i low, both enables are high.
- R8: After reset all three control bytes are 0x00. All control outputs and pulses are then low, sda_oe_o is low, and both output enables are high while squelch_i is low.
- R9: A read of an unmapped or write-only sub-address returns 0x00. A write to a read-only or unmapped sub-address is acknowledged and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| addr_pin_i | input | 1 | Board pin giving address bit 5 |
| rate_fine_i | input | 24 | Fine data-rate measurement word |
| rate_coarse_i | input | 9 | Coarse data-rate measurement word |
| lol_sticky_i | input | 1 | Latched loss-of-lock flag |
| lol_now_i | input | 1 | Live loss-of-lock status (1 = acquiring) |
| meas_done_i | input | 1 | Rate measurement complete flag |
| squelch_i | input | 1 | Request to silence the recovered outputs |
| ref_band_o | output | 2 | Reference frequency band select |
| ratio_code_o | output | 4 | Power-of-two data-rate to reference ratio code |
| meas_start_o | output | 1 | Request a data-rate measurement |
| ref_lock_o | output | 1 | 1 = lock to reference, 0 = lock to data |
| lol_static_o | output | 1 | Lock indicator in latched mode |
| clr_lol_o | output | 1 | One-cycle clear of the latched loss-of-lock flag |
| sys_rst_o | output | 1 | One-cycle receiver reset request |
| clr_meas_o | output | 1 | One-cycle clear of the measurement-complete flag |
| boost_o | output | 1 | Output swing boost |
| data_out_en_o | output | 1 | Recovered data output enable |
| clk_out_en_o | output | 1 | Recovered clock output enable |

## Verification
The bench drives addresses that differ from the target address only in the pin-controlled bit or in the low bits. A design that decodes the address wrongly would acknowledge one of them, or refuse its own address. Reads that start at the end of the fine words, and writes that begin at 0x10, test the auto-increment boundaries. A pointer that failed to advance, or advanced twice, would return the wrong neighbour byte or land a value in the wrong control byte. The clear bits are written with 1, then 0, then 0 again, and the bench counts pulses. A design that triggered on level or on any write would show an extra or a missing pulse. Both squelch policies are exercised with squelch_i high and low, which exposes an enable gated under the wrong policy.

// File: rtl/cdr_i2c_pkg.sv
package cdr_i2c_pkg;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_RX,
    LNK_ACK,
    LNK_TX,
    LNK_MACK
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } byte_phase_t;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] SUB_RATE  = 8'h03;
  localparam logic [7:0] SUB_MISC  = 8'h04;
  localparam logic [7:0] SUB_CFG_A = 8'h08;
  localparam logic [7:0] SUB_CFG_B = 8'h09;
  localparam logic [7:0] SUB_CFG_C = 8'h11;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  // the bus idles high, so the synchroniser resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import cdr_i2c_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] sub_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              busy
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  link_state_t       state_q, state_n;
  byte_phase_t       phase_q, phase_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] ptr_q, ptr_n;
  logic              rw_q, rw_n;
  logic              oe_q, oe_n;
  logic              mack_q, mack_n;
  logic              wr_n;

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    mack_n  = mack_q;
    wr_n    = 1'b0;
    if (stop_det) begin
      state_n = LNK_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = LNK_RX;
      phase_n = PH_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        LNK_RX: begin
          if (scl_rise && (cnt_q != CNT_FULL)) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_FULL)) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (sh_q[BYTE_W-1:1] == dev_addr) begin
                  rw_n    = sh_q[0];
                  state_n = LNK_ACK;
                  oe_n    = 1'b1;
                end else begin
                  state_n = LNK_IDLE;
                end
              end
              PH_SUB: begin
                ptr_n   = sh_q;
                state_n = LNK_ACK;
                oe_n    = 1'b1;
              end
              default: begin
                wr_n    = 1'b1;
                ptr_n   = ptr_q + 1'b1;
                state_n = LNK_ACK;
                oe_n    = 1'b1;
              end
            endcase
          end
        end
        LNK_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if ((phase_q == PH_ADDR) && rw_q) begin
              sh_n    = rd_data;
              ptr_n   = ptr_q + 1'b1;
              state_n = LNK_TX;
              oe_n    = ~rd_data[BYTE_W-1];
            end else begin
              phase_n = (phase_q == PH_ADDR) ? PH_SUB : PH_DATA;
              state_n = LNK_RX;
              oe_n    = 1'b0;
            end
          end
        end
        LNK_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              state_n = LNK_MACK;
              oe_n    = 1'b0;
            end else begin
              sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
              oe_n  = ~sh_q[BYTE_W-2];
            end
          end
        end
        LNK_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_n    = rd_data;
              ptr_n   = ptr_q + 1'b1;
              cnt_n   = '0;
              state_n = LNK_TX;
              oe_n    = ~rd_data[BYTE_W-1];
            end else begin
              state_n = LNK_IDLE;
            end
          end
        end
        default: begin
          oe_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_n_reg_reset();
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
      mack_q  <= mack_n;
    end
  end

  task automatic state_n_reg_reset();
    state_q <= LNK_IDLE;
    phase_q <= PH_ADDR;
    cnt_q   <= '0;
    sh_q    <= '0;
    ptr_q   <= '0;
    rw_q    <= 1'b0;
    oe_q    <= 1'b0;
    mack_q  <= 1'b0;
  endtask

  assign sub_addr = ptr_q;
  assign wr_en    = wr_n;
  assign wr_data  = sh_q;
  assign sda_oe   = oe_q;
  assign busy     = (state_q != LNK_IDLE);

endmodule

// File: rtl/cdr_ctrl_regs.sv
module cdr_ctrl_regs
  import cdr_i2c_pkg::*;
#(
  parameter int unsigned FINE_BYTES = 3,
  parameter int unsigned COARSE_W   = 9,
  parameter int unsigned N_PULSE    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic [BYTE_W-1:0]       rd_addr,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic [8*FINE_BYTES-1:0] rate_fine,
  input  logic [COARSE_W-1:0]     rate_coarse,
  input  logic                    lol_sticky,
  input  logic                    lol_now,
  input  logic                    meas_done,
  output logic [BYTE_W-1:0]       cfg_a,
  output logic [BYTE_W-1:0]       cfg_b,
  output logic [BYTE_W-1:0]       cfg_c,
  output logic [N_PULSE-1:0]      clr_pulse
);

  localparam int unsigned FINE_LAST = FINE_BYTES - 1;

  logic [BYTE_W-1:0]  cfg_a_q, cfg_a_n;
  logic [BYTE_W-1:0]  cfg_b_q, cfg_b_n;
  logic [BYTE_W-1:0]  cfg_c_q, cfg_c_n;
  logic [N_PULSE-1:0] pulse_q, pulse_n;
  logic               hit_a, hit_b, hit_c;

  assign hit_a = wr_en && (wr_addr == SUB_CFG_A);
  assign hit_b = wr_en && (wr_addr == SUB_CFG_B);
  assign hit_c = wr_en && (wr_addr == SUB_CFG_C);

  always_comb begin
    cfg_a_n = cfg_a_q;
    cfg_b_n = cfg_b_q;
    cfg_c_n = cfg_c_q;
    if (hit_a) cfg_a_n = wr_data;
    if (hit_b) cfg_b_n = wr_data;
    if (hit_c) cfg_c_n = wr_data;
  end

  // clear bits fire when a stored 1 is overwritten with 0
  for (genvar k = 0; k < N_PULSE; k++) begin : g_pulse
    localparam int unsigned PB = (k == 0) ? 6 : (k == 1) ? 5 : 3;
    assign pulse_n[k] = hit_b && cfg_b_q[PB] && !wr_data[PB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      cfg_c_q <= '0;
      pulse_q <= '0;
    end else begin
      cfg_a_q <= cfg_a_n;
      cfg_b_q <= cfg_b_n;
      cfg_c_q <= cfg_c_n;
      pulse_q <= pulse_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr <= BYTE_W'(FINE_LAST)) begin
      rd_data = rate_fine[8*rd_addr +: 8];
    end else if (rd_addr == SUB_RATE) begin
      rd_data = rate_coarse[COARSE_W-1:1];
    end else if (rd_addr == SUB_MISC) begin
      rd_data = {3'b000, lol_sticky, lol_now, meas_done, 1'b0, rate_coarse[0]};
    end
  end

  assign cfg_a     = cfg_a_q;
  assign cfg_b     = cfg_b_q;
  assign cfg_c     = cfg_c_q;
  assign clr_pulse = pulse_q;

endmodule

// File: rtl/cdr_i2c_ctrl.sv
module cdr_i2c_ctrl
  import cdr_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FINE_BYTES  = 3,
  parameter int unsigned COARSE_W    = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic                    addr_pin_i,
  input  logic [8*FINE_BYTES-1:0] rate_fine_i,
  input  logic [COARSE_W-1:0]     rate_coarse_i,
  input  logic                    lol_sticky_i,
  input  logic                    lol_now_i,
  input  logic                    meas_done_i,
  input  logic                    squelch_i,
  output logic [1:0]              ref_band_o,
  output logic [3:0]              ratio_code_o,
  output logic                    meas_start_o,
  output logic                    ref_lock_o,
  output logic                    lol_static_o,
  output logic                    clr_lol_o,
  output logic                    sys_rst_o,
  output logic                    clr_meas_o,
  output logic                    boost_o,
  output logic                    data_out_en_o,
  output logic                    clk_out_en_o
);

  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned N_PULSE  = 3;
  localparam int unsigned PIN_BIT  = 5;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] sub_addr, eng_wr_data, rd_data;
  logic              eng_wr_en, eng_busy;
  logic [BYTE_W-1:0] cfg_a, cfg_b, cfg_c;
  logic [N_PULSE-1:0] clr_pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  always_comb begin
    dev_addr          = '0;
    dev_addr[ADDR_W-1] = 1'b1;
    dev_addr[PIN_BIT] = addr_pin_i;
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .sub_addr  (sub_addr),
    .wr_en     (eng_wr_en),
    .wr_data   (eng_wr_data),
    .sda_oe    (sda_oe_o),
    .busy      (eng_busy)
  );

  cdr_ctrl_regs #(
    .FINE_BYTES (FINE_BYTES),
    .COARSE_W   (COARSE_W),
    .N_PULSE    (N_PULSE)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (eng_wr_en),
    .wr_addr     (sub_addr),
    .wr_data     (eng_wr_data),
    .rd_addr     (sub_addr),
    .rd_data     (rd_data),
    .rate_fine   (rate_fine_i),
    .rate_coarse (rate_coarse_i),
    .lol_sticky  (lol_sticky_i),
    .lol_now     (lol_now_i),
    .meas_done   (meas_done_i),
    .cfg_a       (cfg_a),
    .cfg_b       (cfg_b),
    .cfg_c       (cfg_c),
    .clr_pulse   (clr_pulse)
  );

  assign ref_band_o    = cfg_a[7:6];
  assign ratio_code_o  = cfg_a[5:2];
  assign meas_start_o  = cfg_a[1];
  assign ref_lock_o    = cfg_a[0];
  assign lol_static_o  = cfg_b[7];
  assign clr_lol_o     = clr_pulse[0];
  assign sys_rst_o     = clr_pulse[1];
  assign clr_meas_o    = clr_pulse[2];
  assign boost_o       = cfg_c[0];
  assign data_out_en_o = ~squelch_i;
  assign clk_out_en_o  = ~squelch_i | cfg_c[1];

endmodule

// File: rtl/cdr_i2c_ctrl_chk.sv
module cdr_i2c_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       busy,
  input logic       sda_oe,
  input logic       squelch,
  input logic       data_en,
  input logic       clk_en,
  input logic       clr_lol,
  input logic       sys_rst,
  input logic       clr_meas,
  input logic [7:0] band_ctl
);

  // R1: the target only pulls SDA while inside a transfer
  assert_oe_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);

  // R6: every clear pulse follows a write to the 0x09 byte
  assert_pulse_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lol || sys_rst || clr_meas) |-> ($past(wr_en) && ($past(wr_addr) == 8'h09)));

  // R6: a clear pulse lasts one cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lol || sys_rst || clr_meas) |=> !(clr_lol || sys_rst || clr_meas));

  // R5: the 0x08 outputs change only after a write to 0x08
  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == 8'h08)) |=> $stable(band_ctl));

  // R7: squelch always silences data, and never silences anything when low
  assert_squelch_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    squelch |-> !data_en);
  assert_unsquelched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !squelch |-> (data_en && clk_en));

endmodule

bind cdr_i2c_ctrl cdr_i2c_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .wr_en    (eng_wr_en),
  .wr_addr  (sub_addr),
  .busy     (eng_busy),
  .sda_oe   (sda_oe_o),
  .squelch  (squelch_i),
  .data_en  (data_out_en_o),
  .clk_en   (clk_out_en_o),
  .clr_lol  (clr_lol_o),
  .sys_rst  (sys_rst_o),
  .clr_meas (clr_meas_o),
  .band_ctl ({ref_band_o, ratio_code_o, meas_start_o, ref_lock_o})
);

// File: tb/sim_cdr_i2c_ctrl.sv
`timescale 1ns/1ps
module sim_cdr_i2c_ctrl;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe_o;
  wire  sda_line = ~(m_low | sda_oe_o);
  logic addr_pin = 1'b0;
  logic [23:0] fine = '0;
  logic [8:0]  coarse = '0;
  logic sticky = 1'b0, live = 1'b0, done_f = 1'b0, squelch = 1'b0;
  logic [1:0] ref_band_o;
  logic [3:0] ratio_code_o;
  logic meas_start_o, ref_lock_o, lol_static_o, clr_lol_o, sys_rst_o, clr_meas_o;
  logic boost_o, data_out_en_o, clk_out_en_o;

  int total = 0, fails = 0;
  int n_lol = 0, n_rst = 0, n_meas = 0;
  int e_lol = 0, e_rst = 0, e_meas = 0;
  logic [7:0] ma = 8'h00, mb = 8'h00, mc = 8'h00;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cdr_i2c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe_o),
    .addr_pin_i(addr_pin), .rate_fine_i(fine), .rate_coarse_i(coarse),
    .lol_sticky_i(sticky), .lol_now_i(live), .meas_done_i(done_f), .squelch_i(squelch),
    .ref_band_o(ref_band_o), .ratio_code_o(ratio_code_o), .meas_start_o(meas_start_o),
    .ref_lock_o(ref_lock_o), .lol_static_o(lol_static_o), .clr_lol_o(clr_lol_o),
    .sys_rst_o(sys_rst_o), .clr_meas_o(clr_meas_o), .boost_o(boost_o),
    .data_out_en_o(data_out_en_o), .clk_out_en_o(clk_out_en_o)
  );

  always @(posedge clk) begin
    if (clr_lol_o) n_lol++;
    if (sys_rst_o) n_rst++;
    if (clr_meas_o) n_meas++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    m_low = ~b; wq();
    scl = 1'b1; wq();
    r = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic start_c();
    m_low = 1'b0; wq();
    scl = 1'b1; wq();
    m_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic stop_c();
    m_low = 1'b1; wq();
    scl = 1'b1; wq();
    m_low = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, r);
      b = {b[6:0], r};
    end
    bit_x(~give_ack, r);
  endtask

  function automatic logic [7:0] own_addr(input logic rd);
    return {1'b1, addr_pin, 5'b00000, rd};
  endfunction

  function automatic logic [7:0] exp_rb(input logic [7:0] a);
    case (a)
      8'h00: return fine[7:0];
      8'h01: return fine[15:8];
      8'h02: return fine[23:16];
      8'h03: return coarse[8:1];
      8'h04: return {3'b000, sticky, live, done_f, 1'b0, coarse[0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h08) ma = d;
    if (a == 8'h09) begin
      if (mb[6] && !d[6]) e_lol++;
      if (mb[5] && !d[5]) e_rst++;
      if (mb[3] && !d[3]) e_meas++;
      mb = d;
    end
    if (a == 8'h11) mc = d;
  endfunction

  task automatic write_seq(input logic [7:0] sub, input int n, input logic [31:0] data,
                           output logic all_ack);
    logic a;
    all_ack = 1'b1;
    start_c();
    send_byte(own_addr(1'b0), a); all_ack &= a;
    send_byte(sub, a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(data[8*i +: 8], a); all_ack &= a;
      model_wr(sub + 8'(i), data[8*i +: 8]);
    end
    stop_c();
  endtask

  task automatic read_seq(input logic [7:0] sub, input int n, output logic [31:0] data,
                          output logic all_ack);
    logic a;
    logic [7:0] b;
    all_ack = 1'b1;
    data = '0;
    start_c();
    send_byte(own_addr(1'b0), a); all_ack &= a;
    send_byte(sub, a); all_ack &= a;
    start_c();
    send_byte(own_addr(1'b1), a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      data[8*i +: 8] = b;
    end
    stop_c();
  endtask

  task automatic check_outputs(input string req);
    chk({req, " band"}, 32'(ref_band_o), 32'(ma[7:6]));
    chk({req, " ratio"}, 32'(ratio_code_o), 32'(ma[5:2]));
    chk({req, " meas/ref"}, {30'b0, meas_start_o, ref_lock_o}, {30'b0, ma[1], ma[0]});
    chk({req, " lolstatic"}, 32'(lol_static_o), 32'(mb[7]));
    chk({req, " boost"}, 32'(boost_o), 32'(mc[0]));
    chk({req, " pulses"}, {n_lol[7:0], n_rst[7:0], n_meas[7:0]},
        {e_lol[7:0], e_rst[7:0], e_meas[7:0]});
  endtask

  task automatic check_read(input string req, input logic [7:0] sub, input int n);
    logic [31:0] d, e;
    logic ok;
    e = '0;
    for (int i = 0; i < n; i++) e[8*i +: 8] = exp_rb(sub + 8'(i));
    read_seq(sub, n, d, ok);
    chk({req, " read ack"}, 32'(ok), 32'd1);
    chk({req, " read data"}, d, e);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [31:0] d;
    void'($urandom(32'h1c0ffee));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R8: reset state
    check_outputs("R8 reset");
    chk("R8 enables", {30'b0, data_out_en_o, clk_out_en_o}, 32'd3);
    chk("R8 sda idle", 32'(sda_oe_o), 32'd0);

    // R1: address decode, pin 0 then pin 1
    start_c(); send_byte(8'hC0, ok); stop_c();
    chk("R1 pin-bit mismatch nack", 32'(ok), 32'd0);
    start_c(); send_byte(8'h82, ok); stop_c();
    chk("R1 low-bit mismatch nack", 32'(ok), 32'd0);
    start_c(); send_byte(own_addr(1'b0), ok); stop_c();
    chk("R1 own address ack", 32'(ok), 32'd1);
    addr_pin = 1'b1; wq();
    start_c(); send_byte(8'h80, ok); stop_c();
    chk("R1 pin=1 rejects 0x80", 32'(ok), 32'd0);
    start_c(); send_byte(own_addr(1'b0), ok); stop_c();
    chk("R1 pin=1 own address ack", 32'(ok), 32'd1);

    // R4 / R3: readback map with auto-increment, random inputs
    for (int k = 0; k < 3; k++) begin
      fine = 24'($urandom); coarse = 9'($urandom);
      {sticky, live, done_f} = 3'($urandom);
      wq();
      check_read("R4 fine bytes", 8'h00, 3);
      check_read("R3 R4 coarse+misc", 8'h03, 2);
    end
    fine = 24'hA5C3_7E; coarse = 9'h1FF; {sticky, live, done_f} = 3'b101;
    check_read("R4 misc corner", 8'h04, 1);

    // R5 / R2: multi-byte write from 0x08 reaches 0x09
    write_seq(8'h08, 2, {16'h0080, 8'b10_1011_1_1}, ok);
    chk("R2 write acks", 32'(ok), 32'd1);
    check_outputs("R5 R2 cfg after burst");

    // R9: write-only bytes read back 0, RO write ignored, unmapped ignored
    check_read("R9 write-only reads zero", 8'h07, 3);
    write_seq(8'h04, 1, 32'h0000_00FF, ok);
    chk("R9 RO write acked", 32'(ok), 32'd1);
    check_read("R9 RO unchanged", 8'h04, 1);
    write_seq(8'h0A, 2, 32'h0000_FFFF, ok);
    check_outputs("R9 unmapped write ignored");

    // R2 / R7: write from 0x10 lands second byte in 0x11
    write_seq(8'h10, 2, 32'h0000_03FF, ok);
    check_outputs("R2 R7 incr to 0x11");
    squelch = 1'b1; wq();
    chk("R7 policy1 squelch", {30'b0, data_out_en_o, clk_out_en_o}, 32'd1);
    write_seq(8'h11, 1, 32'h0000_0001, ok);
    chk("R7 policy0 squelch", {30'b0, data_out_en_o, clk_out_en_o}, 32'd0);
    squelch = 1'b0; wq();
    chk("R7 unsquelched", {30'b0, data_out_en_o, clk_out_en_o}, 32'd3);

    // R6: 1 then 0 fires, 0 over 0 does not
    write_seq(8'h09, 1, 32'h0000_0068, ok);
    check_outputs("R6 set bits no pulse");
    write_seq(8'h09, 1, 32'h0000_0000, ok);
    check_outputs("R6 clear fires");
    write_seq(8'h09, 1, 32'h0000_0000, ok);
    check_outputs("R6 repeat zero silent");
    write_seq(8'h09, 1, 32'h0000_0040, ok);
    write_seq(8'h09, 1, 32'h0000_0088, ok);
    check_outputs("R6 single bit clear");

    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [7:0] sub;
      case ($urandom % 3)
        0: sub = 8'h08;
        1: sub = 8'h09;
        default: sub = 8'h11;
      endcase
      write_seq(sub, 1, 32'($urandom & 32'hFF), ok);
      check_outputs("R5 R6 R7 random write");
      fine = 24'($urandom); coarse = 9'($urandom);
      {sticky, live, done_f} = 3'($urandom);
      sub = 8'($urandom % 20);
      check_read("R4 R9 random read", sub, 1);
    end

    read_seq(8'h00, 1, d, ok);
    chk("R3 single-byte read", d, {24'b0, fine[7:0]});

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule